// File: doc/BRIEF.md
# Boot configuration command interpreter

This block runs a packed table of configuration commands during early boot. Given a base address and a start pulse, it fetches the table one 32-bit word at a time through a read port. Each stored word is big-endian, and the block swaps it into host order before it uses it. It validates the table header. It then executes each command against a memory-mapped master port. The commands are plain register writes, read-modify-write bit clears and bit sets, polled condition checks with an optional retry limit, and no-ops.

Every target address is compared against a parameterised set of permitted address windows before any bus access is made. Any fault stops the run at once. The block then pulses `err` and holds a code that names the class of fault. A table that ends cleanly pulses `done`.

The read port and the master port each use a request/acknowledge handshake with a single request outstanding. A request stays high, with its address and data steady, until the cycle in which its acknowledge is seen.

Top module: `bootcfg_seq`

## Requirements
- R1: Each word read from the table is byte-reversed before use: stored bytes b0 b1 b2 b3 (b0 in bits 31:24 of `rd_data`) form the host word {b3,b2,b1,b0}. Every host-order field named below refers to the word after this swap.
- R2: Header (host word at the base address) must have 0xD2 in bits 31:24 and 0x40 in bits 7:0. Its bits 23:8 give the total table length in bytes, header included, and that length must be at least 4 and a multiple of 4. Any violation ends the run with error code 1.
- R3: A header length greater than MAX_LEN (default 1768) ends the run with error code 2; a length of exactly MAX_LEN is accepted.
- R4: A command header with tag 0xCC in bits 31:24 is a write command. Its bits 23:8 give its byte length, which counts its own header word and must equal 4+8n. The command is followed by n (address, value) word pairs. With flags (bits 7:3) equal to 0, each pair produces one bus write of the value to the address, in table order.
- R5: For a write command, flags 1 and 3 each cause one bus read of the address, then one bus write of the data read with the value's bits cleared (flags 1) or set (flags 3).
- R6: Command bits 2:0 give the access size in bytes and appear on `bus_size`. For write and check commands, a size other than 1, 2 or 4 ends the run with error code 3. So do write flags other than 0, 1 or 3.
- R7: Tag 0xCF is a check command: an address, then a mask. Bit 4 of the command selects waiting for masked bits set (1) or clear (0). Bit 3 selects any masked bit (1) or all masked bits (0). With length 12 the block re-reads the address until the condition holds.
- R8: A check command of length 16 carries a third word N. At most max(N,1) reads are made, and if none of them meets the condition the run ends with error code 6.
- R9: Tag 0xC0 with length 4 is a no-op and causes no bus access.
- R10: A command tag other than 0xCC, 0xCF or 0xC0 ends the run with error code 3. So does a known tag whose length does not fit its form: a write length that is not 4+8n, a check length that is not 12 or 16, or a no-op length that is not 4.
- R11: A command length below 4, or a command that would extend past the table length, ends the run with error code 4.
- R12: Every write or check address must lie in one of the permitted windows. The defaults are 0x40000000-0x4000FFFF, 0x50000000-0x5FFFFFFF, 0x80000000-0x80000FFF and 0xF0000000-0xF0007FF0. Any other address ends the run with error code 5 before any bus access to it, while the accesses of earlier pairs stand.
- R13: When the last command completes at the table length, `done` is high for exactly one cycle and `err_code` is 0. A fault pulses `err` for one cycle and holds its nonzero code until the next start. `busy` is high from start to the end of the run.
- R14: `rd_req` and `bus_req` are never high together. Each stays high, with its address, write flag and write data unchanged, until its acknowledge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| start | input | 1 | Begin a run (ignored while busy) |
| base_addr | input | 32 | Address of the table header |
| rd_req | output | 1 | Table word read request |
| rd_addr | output | 32 | Table word address |
| rd_ack | input | 1 | Table read acknowledge, data valid |
| rd_data | input | 32 | Table word as stored (big-endian) |
| bus_req | output | 1 | Master port request |
| bus_we | output | 1 | 1 for write, 0 for read |
| bus_addr | output | 32 | Target address |
| bus_wdata | output | 32 | Write data |
| bus_size | output | 3 | Access size in bytes (1, 2 or 4) |
| bus_ack | input | 1 | Master port acknowledge |
| bus_rdata | input | 32 | Read data, valid with acknowledge |
| busy | output | 1 | Run in progress |
| done | output | 1 | One-cycle pulse on clean completion |
| err | output | 1 | One-cycle pulse on a fault |
| err_code | output | 3 | Fault class: 1 header, 2 too long, 3 bad command, 4 overrun, 5 address refused, 6 poll timeout |

## Verification
The hardest situation to reach is a counted poll whose condition turns true on exactly the last permitted read, or just misses it. That requires the register under test to change value after a chosen number of reads. The bench slave holds one poll register that returns one value before a programmed read count and another after it. The directed cases put the change at, just before and beyond the retry limit, and use a zero count, under random acknowledge delays. Partial runs, where an address refused in a later pair must leave the earlier writes in place and stop before the next access, are built by hand. Random programs cover plain, clear and set writes at all sizes.

// File: rtl/bootcfg_seq.sv
module bootcfg_seq #(
  parameter int MAX_LEN = 1768,
  parameter int NUM_WIN = 4,
  parameter logic [NUM_WIN*32-1:0] WIN_LO = {32'hF000_0000, 32'h8000_0000, 32'h5000_0000, 32'h4000_0000},
  parameter logic [NUM_WIN*32-1:0] WIN_HI = {32'hF000_7FF0, 32'h8000_0FFF, 32'h5FFF_FFFF, 32'h4000_FFFF}
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        start,
  input  logic [31:0] base_addr,
  output logic        rd_req,
  output logic [31:0] rd_addr,
  input  logic        rd_ack,
  input  logic [31:0] rd_data,
  output logic        bus_req,
  output logic        bus_we,
  output logic [31:0] bus_addr,
  output logic [31:0] bus_wdata,
  output logic [2:0]  bus_size,
  input  logic        bus_ack,
  input  logic [31:0] bus_rdata,
  output logic        busy,
  output logic        done,
  output logic        err,
  output logic [2:0]  err_code
);
  localparam logic [16:0] MAXL = 17'(MAX_LEN);
  localparam logic [7:0] T_HDR = 8'hD2, T_WR = 8'hCC, T_CHK = 8'hCF, T_NOP = 8'hC0;

  typedef enum logic [2:0] {S_IDLE, S_FETCH, S_NEXT, S_BRD, S_BWR} st_t;
  typedef enum logic [2:0] {F_HDR, F_CMD, F_ADDR, F_VAL, F_CNT} fld_t;

  st_t         st;
  fld_t        fld;
  logic [31:0] base, addr, val, cnt, wdat;
  logic [15:0] pos, tlen, cend;
  logic [4:0]  flg;
  logic [2:0]  sz, code_q, fcode;
  logic        is_chk, counted, done_q, err_q;

  wire [31:0] w    = {rd_data[7:0], rd_data[15:8], rd_data[23:16], rd_data[31:24]};
  wire [7:0]  tag  = w[31:24];
  wire [15:0] clen = w[23:8];
  wire [4:0]  cfl  = w[7:3];
  wire [2:0]  csz  = w[2:0];
  wire [16:0] cend_n = {1'b0, pos} + {1'b0, clen};
  wire sz_ok  = (csz == 3'd1) || (csz == 3'd2) || (csz == 3'd4);
  wire wfl_ok = (cfl == 5'd0) || (cfl == 5'd1) || (cfl == 5'd3);

  logic [NUM_WIN-1:0] hit;
  for (genvar i = 0; i < NUM_WIN; i++) begin : g_win
    assign hit[i] = (w >= WIN_LO[i*32 +: 32]) && (w <= WIN_HI[i*32 +: 32]);
  end

  wire [31:0] msk = bus_rdata & val;
  wire met = flg[1] ? (flg[0] ? (msk != 32'd0) : (msk == val))
                    : (flg[0] ? (msk != val)   : (msk == 32'd0));

  always_comb begin
    fcode = 3'd0;
    if (st == S_FETCH && rd_ack) begin
      case (fld)
        F_HDR: begin
          if (tag != T_HDR || w[7:0] != 8'h40) fcode = 3'd1;
          else if ({1'b0, clen} > MAXL)        fcode = 3'd2;
          else if (clen < 16'd4 || clen[1:0] != 2'd0) fcode = 3'd1;
        end
        F_CMD: begin
          if (tag != T_WR && tag != T_CHK && tag != T_NOP) fcode = 3'd3;
          else if (clen < 16'd4 || cend_n > {1'b0, tlen})  fcode = 3'd4;
          else if (tag == T_WR && (clen[2:0] != 3'd4 || !sz_ok || !wfl_ok)) fcode = 3'd3;
          else if (tag == T_CHK && ((clen != 16'd12 && clen != 16'd16) || !sz_ok)) fcode = 3'd3;
          else if (tag == T_NOP && clen != 16'd4) fcode = 3'd3;
        end
        F_ADDR: if (hit == '0) fcode = 3'd5;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE; fld <= F_HDR;
      base <= '0; addr <= '0; val <= '0; cnt <= '0; wdat <= '0;
      pos <= '0; tlen <= '0; cend <= '0; flg <= '0; sz <= '0;
      is_chk <= 1'b0; counted <= 1'b0;
      done_q <= 1'b0; err_q <= 1'b0; code_q <= '0;
    end else begin
      done_q <= 1'b0;
      err_q  <= 1'b0;
      case (st)
        S_IDLE: if (start) begin
          base <= base_addr; pos <= '0; fld <= F_HDR; code_q <= '0; st <= S_FETCH;
        end
        S_FETCH: if (rd_ack) begin
          pos <= pos + 16'd4;
          if (fcode != 3'd0) begin
            err_q <= 1'b1; code_q <= fcode; st <= S_IDLE;
          end else begin
            case (fld)
              F_HDR: begin tlen <= clen; cend <= 16'd4; st <= S_NEXT; end
              F_CMD: begin
                cend <= cend_n[15:0]; flg <= cfl; sz <= csz;
                is_chk <= (tag == T_CHK); counted <= (clen == 16'd16);
                fld <= F_ADDR;
                st <= (tag == T_CHK) ? S_FETCH : S_NEXT;
              end
              F_ADDR: begin addr <= w; fld <= F_VAL; end
              F_VAL: begin
                val <= w; wdat <= w;
                if (is_chk && counted) fld <= F_CNT;
                else if (!is_chk && flg == 5'd0) st <= S_BWR;
                else st <= S_BRD;
              end
              default: begin cnt <= w; st <= S_BRD; end
            endcase
          end
        end
        S_NEXT: begin
          if (pos != cend) begin
            fld <= F_ADDR; st <= S_FETCH;
          end else if (pos == tlen) begin
            done_q <= 1'b1; st <= S_IDLE;
          end else begin
            fld <= F_CMD; st <= S_FETCH;
          end
        end
        S_BRD: if (bus_ack) begin
          if (!is_chk) begin
            wdat <= flg[1] ? (bus_rdata | val) : (bus_rdata & ~val);
            st <= S_BWR;
          end else if (met) begin
            st <= S_NEXT;
          end else if (counted) begin
            if (cnt <= 32'd1) begin
              err_q <= 1'b1; code_q <= 3'd6; st <= S_IDLE;
            end else begin
              cnt <= cnt - 32'd1;
            end
          end
        end
        S_BWR: if (bus_ack) st <= S_NEXT;
        default: st <= S_IDLE;
      endcase
    end
  end

  assign rd_req    = (st == S_FETCH);
  assign rd_addr   = base + {16'd0, pos};
  assign bus_req   = (st == S_BRD) || (st == S_BWR);
  assign bus_we    = (st == S_BWR);
  assign bus_addr  = addr;
  assign bus_wdata = wdat;
  assign bus_size  = sz;
  assign busy      = (st != S_IDLE);
  assign done      = done_q;
  assign err       = err_q;
  assign err_code  = code_q;
endmodule

// File: rtl/bootcfg_seq_chk.sv
module bootcfg_seq_chk #(
  parameter int NUM_WIN = 4,
  parameter logic [NUM_WIN*32-1:0] WIN_LO = {32'hF000_0000, 32'h8000_0000, 32'h5000_0000, 32'h4000_0000},
  parameter logic [NUM_WIN*32-1:0] WIN_HI = {32'hF000_7FF0, 32'h8000_0FFF, 32'h5FFF_FFFF, 32'h4000_FFFF}
) (
  input logic        clk,
  input logic        rst_n,
  input logic        rd_req,
  input logic [31:0] rd_addr,
  input logic        rd_ack,
  input logic        bus_req,
  input logic        bus_we,
  input logic [31:0] bus_addr,
  input logic [31:0] bus_wdata,
  input logic [2:0]  bus_size,
  input logic        bus_ack,
  input logic        busy,
  input logic        done,
  input logic        err,
  input logic [2:0]  err_code
);
  function automatic logic allowed(input logic [31:0] a);
    allowed = 1'b0;
    for (int i = 0; i < NUM_WIN; i++)
      if (a >= WIN_LO[i*32 +: 32] && a <= WIN_HI[i*32 +: 32]) allowed = 1'b1;
  endfunction

  p_rd_hold_r14: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req && !rd_ack |=> rd_req && $stable(rd_addr));
  p_bus_hold_r14: assert property (@(posedge clk) disable iff (!rst_n)
    bus_req && !bus_ack |=> bus_req && $stable(bus_addr) && $stable(bus_we) && $stable(bus_wdata));
  p_one_port_r14: assert property (@(posedge clk) disable iff (!rst_n)
    !(rd_req && bus_req));
  p_window_r12: assert property (@(posedge clk) disable iff (!rst_n)
    bus_req |-> allowed(bus_addr));
  p_size_r6: assert property (@(posedge clk) disable iff (!rst_n)
    bus_req |-> (bus_size == 3'd1 || bus_size == 3'd2 || bus_size == 3'd4));
  p_done_pulse_r13: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  p_end_idle_r13: assert property (@(posedge clk) disable iff (!rst_n)
    (done || err) |-> !busy && !bus_req && !rd_req);
  p_err_code_r13: assert property (@(posedge clk) disable iff (!rst_n)
    err |-> err_code != 3'd0 && !done);
  p_done_code_r13: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> err_code == 3'd0);
endmodule

bind bootcfg_seq bootcfg_seq_chk #(.NUM_WIN(NUM_WIN), .WIN_LO(WIN_LO), .WIN_HI(WIN_HI)) u_chk (
  .clk(clk), .rst_n(rst_n), .rd_req(rd_req), .rd_addr(rd_addr), .rd_ack(rd_ack),
  .bus_req(bus_req), .bus_we(bus_we), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
  .bus_size(bus_size), .bus_ack(bus_ack), .busy(busy), .done(done), .err(err),
  .err_code(err_code));

// File: tb/sim_bootcfg_seq.sv
`timescale 1ns/1ps
module sim_bootcfg_seq;
  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic rst_n = 1'b0, start = 1'b0;
  logic [31:0] base_addr;
  logic rd_req, rd_ack = 1'b0, bus_req, bus_we, bus_ack = 1'b0, busy, done, err;
  logic [31:0] rd_addr, rd_data = '0, bus_addr, bus_wdata, bus_rdata = '0;
  logic [2:0] bus_size, err_code;

  bootcfg_seq u0 (.clk(clk), .rst_n(rst_n), .start(start), .base_addr(base_addr),
    .rd_req(rd_req), .rd_addr(rd_addr), .rd_ack(rd_ack), .rd_data(rd_data),
    .bus_req(bus_req), .bus_we(bus_we), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_size(bus_size), .bus_ack(bus_ack), .bus_rdata(bus_rdata),
    .busy(busy), .done(done), .err(err), .err_code(err_code));

  localparam logic [31:0] BASE   = 32'h0000_2000;
  localparam logic [31:0] POLL_A = 32'h4000_0100;
  logic [31:0] wlo [4] = '{32'h4000_0000, 32'h5000_0000, 32'h8000_0000, 32'hF000_0000};
  logic [31:0] whi [4] = '{32'h4000_FFFF, 32'h5FFF_FFFF, 32'h8000_0FFF, 32'hF000_7FF0};

  typedef struct packed { logic we; logic [2:0] sz; logic [31:0] a; logic [31:0] d; } txn_t;
  txn_t expq[$];
  logic [31:0] sw [0:511];
  int nw;
  logic [31:0] smem [logic [31:0]];
  logic [31:0] pmem [logic [31:0]];
  logic [31:0] poll_before, poll_after;
  int poll_flip, poll_cnt, bpcnt;
  int errors = 0, checks = 0;
  string cur_req = "R13";

  function automatic logic [31:0] swap32(input logic [31:0] x);
    return {x[7:0], x[15:8], x[23:16], x[31:24]};
  endfunction
  function automatic logic [31:0] dflt(input logic [31:0] a);
    return a ^ 32'h5A3C_0F00;
  endfunction
  function automatic logic met(input logic [31:0] r, input logic [31:0] m, input logic [1:0] fl);
    logic [31:0] x = r & m;
    case (fl)
      2'b10: return x == m;
      2'b11: return x != 0;
      2'b00: return x == 0;
      default: return x != m;
    endcase
  endfunction

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  // stream read port with random wait states (R14)
  int rw = 0;
  always @(negedge clk) begin
    if (rd_ack) rd_ack = 1'b0;
    else if (rd_req) begin
      if (rw > 0) rw--;
      else begin
        automatic logic [31:0] idx = (rd_addr - BASE) >> 2;
        rd_data = (idx < 512) ? swap32(sw[idx[8:0]]) : 32'hDEAD_BEEF;
        rd_ack = 1'b1;
        rw = $urandom % 3;
      end
    end
  end

  // master port slave, logs and compares each transfer
  int bw = 0;
  always @(negedge clk) begin
    if (bus_ack) bus_ack = 1'b0;
    else if (bus_req) begin
      if (bw > 0) bw--;
      else begin
        automatic txn_t t;
        t.we = bus_we; t.sz = bus_size; t.a = bus_addr;
        if (bus_we) begin
          t.d = bus_wdata; smem[bus_addr] = bus_wdata;
        end else begin
          if (bus_addr == POLL_A) begin
            t.d = (poll_cnt >= poll_flip) ? poll_after : poll_before; poll_cnt++;
          end else t.d = smem.exists(bus_addr) ? smem[bus_addr] : dflt(bus_addr);
          bus_rdata = t.d;
        end
        checks++;
        if (expq.size() == 0) begin
          errors++;
          $display("FAIL %s transfer: actual %h expected none", cur_req, t);
        end else begin
          if (t != expq[0]) begin
            errors++;
            $display("FAIL %s transfer: actual %h expected %h", cur_req, t, expq[0]);
          end
          void'(expq.pop_front());
        end
        bus_ack = 1'b1;
        bw = $urandom % 3;
      end
    end
  end

  task automatic t_new();
    nw = 1; expq.delete(); smem.delete(); pmem.delete();
    poll_cnt = 0; bpcnt = 0; poll_flip = 0; poll_before = '0; poll_after = '0;
  endtask
  task automatic put(input logic [31:0] x); sw[nw] = x; nw++; endtask
  task automatic t_close(); sw[0] = {8'hD2, 16'(nw * 4), 8'h40}; endtask
  task automatic wr_hdr(input logic [4:0] fl, input logic [2:0] sz, input int n);
    put({8'hCC, 16'(4 + 8 * n), fl, sz});
  endtask
  task automatic add_pair(input logic [4:0] fl, input logic [2:0] sz,
                          input logic [31:0] a, input logic [31:0] v);
    put(a); put(v);
    if (fl == 5'd0) begin
      expq.push_back({1'b1, sz, a, v}); pmem[a] = v;
    end else begin
      automatic logic [31:0] old = pmem.exists(a) ? pmem[a] : dflt(a);
      automatic logic [31:0] nv = fl[1] ? (old | v) : (old & ~v);
      expq.push_back({1'b0, sz, a, old});
      expq.push_back({1'b1, sz, a, nv}); pmem[a] = nv;
    end
  endtask
  function automatic logic [31:0] rand_addr();
    automatic int k = $urandom % 4;
    automatic logic [31:0] a = (wlo[k] + ($urandom % (whi[k] - wlo[k] + 1))) & ~32'd3;
    if (a == POLL_A) a = a + 4;
    return a;
  endfunction
  task automatic add_chk(input bit counted, input logic [1:0] fl, input logic [31:0] m,
                         input logic [31:0] n, output bit tmo);
    automatic int lim = (n == 0) ? 1 : int'(n);
    put({8'hCF, counted ? 16'd16 : 16'd12, 3'b000, fl, 3'd4});
    put(POLL_A); put(m);
    if (counted) put(n);
    tmo = 0;
    for (int k = 0; k < 1000; k++) begin
      automatic logic [31:0] r = (bpcnt >= poll_flip) ? poll_after : poll_before;
      bpcnt++;
      expq.push_back({1'b0, 3'd4, POLL_A, r});
      if (met(r, m, fl)) break;
      if (counted && k + 1 >= lim) begin tmo = 1; break; end
    end
  endtask

  task automatic run(input logic [2:0] exp_code, input string req);
    int n = 0;
    bit dseen = 0, eseen = 0;
    cur_req = req;
    base_addr = BASE;
    @(negedge clk) start = 1'b1;
    @(negedge clk) start = 1'b0;
    while (!dseen && !eseen && n < 60000) begin
      if (done) dseen = 1;
      if (err) eseen = 1;
      if (!dseen && !eseen) begin @(negedge clk); n++; end
    end
    chk(n < 60000, req, "run finished", 32'(n), 32'd60000);
    if (exp_code == 3'd0) chk(dseen && !eseen, req, "done pulse", {31'd0, dseen}, 32'd1);
    else chk(eseen && !dseen, req, "err pulse", {31'd0, eseen}, 32'd1);
    chk(err_code == exp_code, req, "err_code", {29'd0, err_code}, {29'd0, exp_code});
    chk(expq.size() == 0, req, "missing transfers", 32'(expq.size()), 32'd0);
    @(negedge clk);
    chk(!done && !err && !busy, req, "idle after run", {29'd0, done, err, busy}, 32'd0);
    repeat (2) @(negedge clk);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog: actual hung expected finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    bit tmo;
    void'($urandom(32'd2024));
    base_addr = BASE;
    repeat (3) @(negedge clk);
    chk(!busy && !done && !err && err_code == 0 && !rd_req && !bus_req, "R13", "reset state",
        {26'd0, busy, done, err, err_code}, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);

    t_new(); t_close(); run(3'd0, "R2 R13 header only");

    t_new(); t_close(); sw[0] = {8'hD3, 16'd4, 8'h40}; run(3'd1, "R2 bad tag");
    t_new(); t_close(); sw[0] = {8'hD2, 16'd4, 8'h41}; run(3'd1, "R2 bad version");
    t_new(); add_nop_put(); t_close(); sw[0] = {8'hD2, 16'd6, 8'h40}; run(3'd1, "R2 misaligned length");
    t_new(); t_close(); sw[0] = {8'hD2, 16'd0, 8'h40}; run(3'd1, "R2 zero length");

    t_new(); for (int i = 0; i < 441; i++) add_nop_put(); t_close();
    run(3'd0, "R3 R9 length at limit");
    sw[0] = {8'hD2, 16'd1772, 8'h40}; run(3'd2, "R3 length over limit");

    t_new(); wr_hdr(5'd0, 3'd4, 1); add_pair(5'd0, 3'd4, 32'h8000_0010, 32'h0102_0304); t_close();
    run(3'd0, "R1 R4 byte order");

    t_new();
    wr_hdr(5'd0, 3'd4, 1); add_pair(5'd0, 3'd4, 32'h5000_0040, 32'hFF00_FF00);
    wr_hdr(5'd1, 3'd2, 1); add_pair(5'd1, 3'd2, 32'h5000_0040, 32'h0F00_0F00);
    wr_hdr(5'd3, 3'd1, 1); add_pair(5'd3, 3'd1, 32'h5000_0040, 32'h0000_00AA);
    t_close(); run(3'd0, "R5 R6 clear and set");
    chk(smem[32'h5000_0040] == 32'hF000_F0AA, "R5", "final register", smem[32'h5000_0040], 32'hF000_F0AA);

    for (int it = 0; it < 24; it++) begin
      automatic int nc = 1 + $urandom % 5;
      automatic bit had_chk = 0;
      t_new();
      for (int c = 0; c < nc; c++) begin
        automatic int kind = $urandom % 5;
        if (kind == 4 && !had_chk) begin
          automatic logic [1:0] fl = 2'($urandom);
          automatic logic [31:0] m = $urandom | 32'h1;
          had_chk = 1;
          poll_flip = $urandom % 4; poll_before = $urandom;
          poll_after = fl[1] ? (poll_before | m) : (poll_before & ~m);
          add_chk(0, fl, m, 0, tmo);
        end else if (kind == 3) add_nop_put();
        else begin
          automatic logic [4:0] fl = (kind == 0) ? 5'd0 : (kind == 1) ? 5'd1 : 5'd3;
          automatic logic [2:0] sz = ($urandom % 3 == 0) ? 3'd1 : ($urandom % 2 == 0) ? 3'd2 : 3'd4;
          automatic int np = $urandom % 4;
          wr_hdr(fl, sz, np);
          for (int p = 0; p < np; p++) add_pair(fl, sz, rand_addr(), $urandom);
        end
      end
      t_close(); run(3'd0, "R1 R4 R5 R7 R14 random program");
    end

    for (int f = 0; f < 4; f++) begin
      t_new(); poll_flip = 3; poll_before = 32'h0000_0030; poll_after = f[1] ? 32'h0000_00F5 : 32'h0000_0005;
      add_chk(0, 2'(f), 32'h0000_00F0, 0, tmo); t_close();
      run(3'd0, "R7 check mode");
    end

    t_new(); poll_flip = 2; poll_before = 0; poll_after = 32'h8;
    add_chk(1, 2'b10, 32'h8, 3, tmo); t_close();
    chk(!tmo, "R8", "model met on last read", {31'd0, tmo}, 0);
    run(3'd0, "R8 met on last permitted read");
    t_new(); poll_flip = 3; poll_before = 0; poll_after = 32'h8;
    add_chk(1, 2'b10, 32'h8, 3, tmo); t_close(); run(3'd6, "R8 timeout by one");
    t_new(); poll_flip = 100; poll_before = 0; poll_after = 0;
    add_chk(1, 2'b10, 32'h8, 0, tmo); t_close(); run(3'd6, "R8 zero count one read");

    t_new(); put({8'hC5, 16'd4, 8'h00}); t_close(); run(3'd3, "R10 unknown tag");
    t_new(); put({8'hCC, 16'd8, 8'h04}); put(32'h4000_0000); t_close(); run(3'd3, "R10 write length form");
    t_new(); put({8'hCF, 16'd20, 8'h04}); for (int i = 0; i < 4; i++) put(POLL_A); t_close();
    run(3'd3, "R10 check length form");
    t_new(); put({8'hC0, 16'd8, 8'h00}); put(0); t_close(); run(3'd3, "R10 no-op length form");
    t_new(); wr_hdr(5'd0, 3'd3, 0); t_close(); run(3'd3, "R6 bad size");
    t_new(); wr_hdr(5'd2, 3'd4, 0); t_close(); run(3'd3, "R6 bad write flags");

    t_new(); wr_hdr(5'd0, 3'd4, 2); put(32'h4000_0000); put(1); t_close(); run(3'd4, "R11 command past table");
    t_new(); put({8'hC0, 16'd0, 8'h00}); t_close(); run(3'd4, "R11 zero length");

    t_new(); wr_hdr(5'd0, 3'd4, 3);
    add_pair(5'd0, 3'd4, 32'h4000_FFFC, 32'h1111_2222);
    put(32'h4001_0000); put(32'h3333_4444); put(32'h4000_0000); put(5); t_close();
    run(3'd5, "R12 address past window");
    t_new(); put({8'hCF, 16'd12, 8'h14}); put(32'h7000_0000); put(1); t_close();
    run(3'd5, "R12 check address refused");

    t_new(); add_nop_put(); t_close(); run(3'd0, "R9 R13 code cleared on restart");

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  task automatic add_nop_put(); put({8'hC0, 16'd4, 8'h00}); endtask
endmodule